// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block keeps one free-running up-counter and a set of comparator channels that share it. Each channel holds a target value. When the counter reaches that target while the channel is enabled, the channel latches an event into its own status bit and drives its own interrupt line. A channel can run in one-shot mode, where the target stays where software put it. It can also run in periodic mode, where the hardware adds a stored interval to the target at each event so the next event is already armed.

The counter advances on a clock-enable pulse (`tick`) that is kept separate from the register clock. This lets a slower timebase of 10 MHz or more drive the count while the register side runs at the system clock. Everything is programmed through a flat, word-addressed register space with single-cycle writes and combinational reads. The data bus is as wide as the counter.

Top module: `evt_timer`

The register map is as follows. Word 0 is control, and bit 0 is the run enable. Word 1 is the counter. Word 2 is event status, with bit i belonging to channel i and cleared by writing 1. Channel i uses the three words that start at 4+4i. The first is configuration: bit 0 is the channel enable and bit 1 selects periodic mode. The second is the target value and the third is the period.

## Requirements
- R1: After reset the counter, the control word, the status word, every channel's configuration, target and period read as zero, and every `irq` bit is low.
- R2: While the run bit is 1, the counter grows by exactly one on each cycle where `tick` is high, wrapping modulo 2^CNT_W. Otherwise it holds its value.
- R3: A write to the counter word loads the written value only while the run bit is 0. While the run bit is 1, the write has no effect.
- R4: An enabled channel records an event on a cycle where the run bit is 1, `tick` is high and the counter equals its target. Its status bit reads 1 from the next cycle on. A disabled channel never records one.
- R5: A status bit stays set until software writes 1 to that bit position of the status word. Writing 0 leaves it alone. A new event in the same cycle as the clear wins, and the bit stays 1.
- R6: In periodic mode the target becomes (target + period) modulo 2^CNT_W on the cycle after each event. A software write to the target in the same cycle takes precedence.
- R7: In one-shot mode an event leaves the target unchanged.
- R8: `irq[i]` is high exactly when status bit i and channel i's enable bit are both 1.
- R9: Control, configuration, target and period words read back what was last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
The bench uses an 8-bit counter and three channels. For every channel, it sweeps the target over all 256 values. In each step the counter is started three counts early, so the test can tell apart an event that is missed, one that fires early and one that fires on the exact count, including across the wrap from 255 to 0. Separate patterns follow. Periodic re-arming is run twice in a row and across the modulo boundary of the target. A one-shot event is run to show the target is left alone. A clear is made to coincide with a fresh event. Writes to the counter are tried in each run state, and channels are toggled while their status is pending, which separates the status bit from the interrupt gate.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_COUNT  = 1;
  localparam int REG_STATUS = 2;
  localparam int CH_BASE    = 4;
  localparam int CH_STRIDE  = 4;
  localparam int SUB_CFG    = 0;
  localparam int SUB_TARGET = 1;
  localparam int SUB_PERIOD = 2;

  typedef struct packed {
    logic periodic;
    logic enable;
  } ch_cfg_t;
endpackage

// File: rtl/evt_counter.sv
`timescale 1ns/1ps
module evt_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (run && tick)    count <= count + 1'b1;
    else if (!run && load)   count <= load_val;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> count == W'($past(count) + 1'b1));

  assert_count_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(count));
endmodule

// File: rtl/evt_channel.sv
`timescale 1ns/1ps
module evt_channel
  import evt_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic         step,
  input  logic         cfg_we,
  input  logic         target_we,
  input  logic         period_we,
  input  logic [W-1:0] wdata,
  output ch_cfg_t      cfg,
  output logic [W-1:0] target,
  output logic [W-1:0] period,
  output logic         hit
);
  assign hit = cfg.enable && step && (count == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      period <= '0;
    end else begin
      if (cfg_we)    cfg    <= ch_cfg_t'(wdata[1:0]);
      if (period_we) period <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   target <= '0;
    else if (target_we)           target <= wdata;
    else if (hit && cfg.periodic) target <= target + period;
  end

  assert_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cfg.periodic && !target_we) |=> target == W'($past(target) + $past(period)));

  assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cfg.periodic && !target_we) |=> $stable(target));
endmodule

// File: rtl/evt_status.sv
`timescale 1ns/1ps
module evt_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] enable,
  output logic [N-1:0] status,
  output logic [N-1:0] irq
);
  logic [N-1:0] clr_bits;
  assign clr_bits = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_bits) | hit;
  end

  assign irq = status & enable;

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> status[i]);
    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_mask[i] && !hit[i]) |=> !status[i]);
  end
endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer
  import evt_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [NCH-1:0]    irq
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(REG_CTRL);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(REG_COUNT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);

  logic             run;
  logic [CNT_W-1:0] count;
  logic             step;
  logic [NCH-1:0]   hit, status, ch_en;
  ch_cfg_t          ch_cfg    [NCH];
  logic [CNT_W-1:0] ch_target [NCH];
  logic [CNT_W-1:0] ch_period [NCH];

  assign step = run && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run <= 1'b0;
    else if (wr_en && wr_addr == A_CTRL) run <= wr_data[0];
  end

  evt_counter #(.W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .load     (wr_en && wr_addr == A_COUNT),
    .load_val (wr_data),
    .count    (count)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CH_BASE + CH_STRIDE*i + SUB_CFG);
    localparam logic [ADDR_W-1:0] A_TGT = ADDR_W'(CH_BASE + CH_STRIDE*i + SUB_TARGET);
    localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(CH_BASE + CH_STRIDE*i + SUB_PERIOD);

    evt_channel #(.W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .count     (count),
      .step      (step),
      .cfg_we    (wr_en && wr_addr == A_CFG),
      .target_we (wr_en && wr_addr == A_TGT),
      .period_we (wr_en && wr_addr == A_PER),
      .wdata     (wr_data),
      .cfg       (ch_cfg[i]),
      .target    (ch_target[i]),
      .period    (ch_period[i]),
      .hit       (hit[i])
    );
    assign ch_en[i] = ch_cfg[i].enable;
  end

  evt_status #(.N(NCH)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .clr_we   (wr_en && wr_addr == A_STATUS),
    .clr_mask (wr_data[NCH-1:0]),
    .enable   (ch_en),
    .status   (status),
    .irq      (irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL)   rd_data = CNT_W'(run);
    if (rd_addr == A_COUNT)  rd_data = count;
    if (rd_addr == A_STATUS) rd_data = CNT_W'(status);
    for (int k = 0; k < NCH; k++) begin
      if (rd_addr == ADDR_W'(CH_BASE + CH_STRIDE*k + SUB_CFG))    rd_data = CNT_W'(ch_cfg[k]);
      if (rd_addr == ADDR_W'(CH_BASE + CH_STRIDE*k + SUB_TARGET)) rd_data = ch_target[k];
      if (rd_addr == ADDR_W'(CH_BASE + CH_STRIDE*k + SUB_PERIOD)) rd_data = ch_period[k];
    end
  end

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch_en[0]) |-> !irq[0]);
endmodule

// File: tb/evt_timer_test.sv
`timescale 1ns/1ps
module evt_timer_test;
  localparam int W = 8;
  localparam int N = 3;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic [N-1:0] irq;
  int checks = 0, errors = 0;
  bit done = 0;

  evt_timer #(.CNT_W(W), .NCH(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #2 clk = ~clk;

  function automatic int a_cfg(int c); return 4 + 4*c; endfunction
  function automatic int a_tgt(int c); return 5 + 4*c; endfunction
  function automatic int a_per(int c); return 6 + 4*c; endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = W'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wr_tick(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = W'(d); tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = AW'(a); #0.5; v = int'(rd_data);
  endtask

  task automatic setup_count(input int v);
    wr(0, 0); wr(1, v); wr(0, 1);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 count", v, 0);
    rd(2, v); chk("R1 status", v, 0);
    chk("R1 irq", int'(irq), 0);
    for (int c = 0; c < N; c++) begin
      rd(a_cfg(c), v); chk("R1 cfg", v, 0);
      rd(a_tgt(c), v); chk("R1 target", v, 0);
      rd(a_per(c), v); chk("R1 period", v, 0);
    end
    // R2 counting and holding
    ticks(2); rd(1, v); chk("R2 stopped", v, 0);
    wr(0, 1); ticks(5); rd(1, v); chk("R2 five ticks", v, 5);
    repeat (4) @(negedge clk); rd(1, v); chk("R2 hold no tick", v, 5);
    // R3 write gated by run
    wr(1, 77); rd(1, v); chk("R3 ignored while running", v, 5);
    wr(0, 0); wr(1, 77); rd(1, v); chk("R3 loaded while stopped", v, 77);
    // R2 wrap
    wr(1, 255); wr(0, 1); ticks(1); rd(1, v); chk("R2 wrap", v, 0);
    // R4 exhaustive target sweep per channel
    for (int c = 0; c < N; c++) begin
      for (int m = 0; m < 256; m++) begin
        wr(a_tgt(c), m); wr(a_cfg(c), 1);
        setup_count((m + 253) % 256);
        ticks(3); rd(2, v); chk("R4 no early event", (v >> c) & 1, 0);
        ticks(1); rd(2, v); chk("R4 event on match", v, 1 << c);
        chk("R8 irq on event", int'(irq), 1 << c);
        wr(2, 1 << c); wr(a_cfg(c), 0);
      end
    end
    // R4 disabled channel
    wr(a_tgt(1), 40); setup_count(40); ticks(2); rd(2, v); chk("R4 disabled no event", v, 0);
    // R5 sticky, write-zero, set wins
    wr(a_tgt(0), 20); wr(a_cfg(0), 1); setup_count(20); ticks(1);
    wr(2, 0); rd(2, v); chk("R5 write zero keeps", v, 1);
    setup_count(20); wr_tick(2, 1); rd(2, v); chk("R5 set beats clear", v, 1);
    wr(2, 1); rd(2, v); chk("R5 clear", v, 0);
    wr(a_cfg(0), 0);
    // R6 periodic
    wr(a_cfg(2), 3); wr(a_tgt(2), 10); wr(a_per(2), 7); setup_count(10); ticks(1);
    rd(a_tgt(2), v); chk("R6 rearm", v, 17);
    wr(2, 4); ticks(6); rd(2, v); chk("R6 quiet before", v, 0);
    ticks(1); rd(2, v); chk("R6 second event", v, 4);
    rd(a_tgt(2), v); chk("R6 rearm twice", v, 24);
    wr(a_tgt(2), 250); wr(a_per(2), 10); setup_count(250); ticks(1);
    rd(a_tgt(2), v); chk("R6 target wraps", v, 4);
    wr(a_cfg(2), 0); wr(2, 4);
    // R7 one-shot
    wr(a_cfg(1), 1); wr(a_per(1), 9); wr(a_tgt(1), 30); setup_count(30); ticks(1);
    rd(a_tgt(1), v); chk("R7 target kept", v, 30);
    // R8 irq gate
    wr(a_cfg(1), 0); rd(2, v);
    chk("R8 status pending", v, 2); chk("R8 irq masked", int'(irq), 0);
    wr(a_cfg(1), 1); chk("R8 irq unmasked", int'(irq), 2);
    // R9 readback
    for (int c = 0; c < N; c++) begin
      wr(a_cfg(c), c); wr(a_tgt(c), 100 + c); wr(a_per(c), 200 + c);
    end
    for (int c = 0; c < N; c++) begin
      rd(a_cfg(c), v); chk("R9 cfg", v, c);
      rd(a_tgt(c), v); chk("R9 target", v, 100 + c);
      rd(a_per(c), v); chk("R9 period", v, 200 + c);
    end
    wr(0, 1); rd(0, v); chk("R9 ctrl", v, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule